// File: doc/BRIEF.md
# Caption Line Interrupt Generator

This block times one selected video line inside each field and tells the processor when caption bytes on that line are ready to read. It counts half-lines from the start of the field and compares the count with a 6-bit line selector that software writes. It keeps a line-window signal high while the count equals the selector. On one edge of that window it raises an interrupt request. Software chooses which edge. With the rising edge, the handler runs at the start of the line. It can then reprogram the selector for the adjacent line and switch to the falling edge, so the end of the same window triggers a second service.

Horizontal timing comes from one of two sources: sync taken from the incoming video, or external deflection pulses. A separate midpoint strobe, arriving half a line after each horizontal pulse, supplies the second tick of each line. Vertical sync always restarts the count. For an NTSC field-1 line N, software writes 2N−9; for field 2 it writes 2N−8 (line 21 gives 33 and 34). The CPU interrupt line carries either the pending flag of this block or an external interrupt pin, as a source bit selects. All pins are plain level or pulse signals with no handshake. Pulse inputs are synchronous to `clk`, and their rising edges count as events.

Top module: `caption_line_irq`

## Requirements
- R1: After reset both register readbacks are 0x00, `line_win` is 0 and `cpu_irq` is 0.
- R2: After the block is enabled, the half-line count stays at zero and `line_win` stays 0 until the first vertical sync rising edge. This holds even when the selector is 0.
- R3: A vertical sync rising edge restarts the count at 0. Each rising edge of the chosen horizontal source or of `mid_strobe` advances it by one. `line_win` is 1 exactly while the count equals the selector (line register bits 5:0, address 0).
- R4: The count saturates at 63 and does not wrap. A window on selector 63 stays high through further half-line ticks, and no new request occurs.
- R5: With the rise-select bit (line register bit 6) at 1, a request is issued when `line_win` rises. A fall of the window issues none.
- R6: With the rise-select bit at 0, a request is issued when `line_win` falls. A rise of the window issues none.
- R7: A request sets the pending flag (mode register bit 6, read-only). Any write to the mode register (address 1) clears the flag. If a request and such a write happen in the same cycle, the flag is set.
- R8: With the source bit (mode register bit 5) at 0, `cpu_irq` follows the pending flag. With it at 1, `cpu_irq` follows `ext_irq`.
- R9: With the horizontal-source bit (line register bit 7) at 1, `hsync_vid` drives the half-line count and `hdefl_pulse` is ignored. With it at 0, the roles swap.
- R10: A write to the selector or to the rise-select bit while the window is high does not move `line_win` before the next half-line tick. Such a write never raises a request by itself.
- R11: While the enable bit (mode register bit 7) is 0, the count is held at zero, `line_win` is 0, and the pending flag cannot be set. Disabling an open window issues no request.
- R12: `line_win` reflects a tick or vertical sync edge two cycles after the cycle in which the edge is first seen. The pending flag and `cpu_irq` follow one cycle later. A register write is visible on the readbacks the cycle after it is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects the line register, 1 selects the mode register |
| wr_data | input | 8 | Write data |
| hsync_vid | input | 1 | Horizontal sync recovered from video |
| hdefl_pulse | input | 1 | External horizontal deflection pulse |
| mid_strobe | input | 1 | Pulse half a line after each horizontal pulse |
| vsync | input | 1 | Vertical sync from video |
| ext_irq | input | 1 | External interrupt pin |
| line_cfg_rd | output | 8 | Line register readback |
| mode_rd | output | 8 | Mode register readback with the pending flag |
| line_win | output | 1 | High while the count equals the selector |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
An input edge driven just after clock edge c is registered at c+1, the count and a step strobe update there, `line_win` and the request update at c+2, and the pending flag and `cpu_irq` are due at c+3. A write driven after edge c is captured at c+1 and is read back at the next sample. The bench scoreboard records each expectation together with its absolute due cycle. The monitor samples on the falling clock edge, compares only the entries due in that cycle, and counts any entry left unchecked as a failure. Several entries check that `line_win` is still low one cycle early, so a design that answers a cycle too soon or too late is caught.

// File: rtl/cli_pkg.sv
package cli_pkg;
  localparam int unsigned LN_W   = 6;
  localparam int unsigned REG_W  = 8;
  localparam logic        A_LINE = 1'b0;
  localparam logic        A_MODE = 1'b1;

  typedef logic [LN_W-1:0] ln_t;

  typedef struct packed {
    logic hsrc_vid;
    logic rise_sel;
    ln_t  ln;
  } line_cfg_t;

  typedef struct packed {
    logic en;
    logic src_ext;
  } mode_cfg_t;
endpackage

// File: rtl/cli_edge_src.sv
module cli_edge_src #(
  parameter int unsigned N_CH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] lvl,
  output logic [N_CH-1:0] rise
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q;
  end
endmodule

// File: rtl/cli_hl_counter.sv
module cli_hl_counter
  import cli_pkg::*;
#(
  parameter int unsigned CW = LN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          vs_rise,
  output logic [CW-1:0] count,
  output logic          started,
  output logic          step
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      started <= 1'b0;
      step    <= 1'b0;
    end else if (!en) begin
      count   <= '0;
      started <= 1'b0;
      step    <= 1'b0;
    end else begin
      step <= tick | vs_rise;
      if (vs_rise) begin
        count   <= '0;
        started <= 1'b1;
      end else if (tick && started && count != CMAX) begin
        count <= count + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cli_line_window.sv
module cli_line_window
  import cli_pkg::*;
#(
  parameter int unsigned CW = LN_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic          started,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] ln,
  input  logic          rise_sel,
  output logic          win,
  output logic          req
);
  logic hit;
  assign hit = started && (count == ln);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win <= 1'b0;
      req <= 1'b0;
    end else if (!en) begin
      win <= 1'b0;
      req <= 1'b0;
    end else begin
      req <= 1'b0;
      if (step) begin
        win <= hit;
        if (rise_sel && hit && !win)  req <= 1'b1;
        if (!rise_sel && !hit && win) req <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cli_regs.sv
module cli_regs
  import cli_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             req,
  input  logic             ext_irq,
  output line_cfg_t        line_cfg,
  output mode_cfg_t        mode_cfg,
  output logic             pend,
  output logic [REG_W-1:0] line_cfg_rd,
  output logic [REG_W-1:0] mode_rd,
  output logic             cpu_irq
);
  logic wr_line, wr_mode;
  logic unused_wr_bits;

  assign wr_line        = wr_en && (wr_addr == A_LINE);
  assign wr_mode        = wr_en && (wr_addr == A_MODE);
  assign unused_wr_bits = ^{wr_data[6], wr_data[4:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cfg <= '0;
      mode_cfg <= '0;
      pend     <= 1'b0;
    end else begin
      if (wr_line) line_cfg <= line_cfg_t'(wr_data);
      if (wr_mode) begin
        mode_cfg.en      <= wr_data[7];
        mode_cfg.src_ext <= wr_data[5];
      end
      if (req && mode_cfg.en) pend <= 1'b1;
      else if (wr_mode)       pend <= 1'b0;
    end
  end

  assign line_cfg_rd = line_cfg;
  assign mode_rd     = {mode_cfg.en, pend, mode_cfg.src_ext, 5'b0};
  assign cpu_irq     = mode_cfg.src_ext ? ext_irq : pend;
endmodule

// File: rtl/caption_line_irq.sv
module caption_line_irq
  import cli_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  input  logic             hsync_vid,
  input  logic             hdefl_pulse,
  input  logic             mid_strobe,
  input  logic             vsync,
  input  logic             ext_irq,
  output logic [REG_W-1:0] line_cfg_rd,
  output logic [REG_W-1:0] mode_rd,
  output logic             line_win,
  output logic             cpu_irq
);
  localparam int unsigned N_CH = 3;

  line_cfg_t       line_cfg;
  mode_cfg_t       mode_cfg;
  logic            en_q, pend_q, req_q, step_q, started_q;
  logic [LN_W-1:0] count_q;
  logic [N_CH-1:0] lvl, rise;
  logic            hsrc, tick, vs_rise;

  assign hsrc    = line_cfg.hsrc_vid ? hsync_vid : hdefl_pulse;
  assign lvl     = {vsync, mid_strobe, hsrc};
  assign tick    = rise[0] | rise[1];
  assign vs_rise = rise[2];
  assign en_q    = mode_cfg.en;

  cli_edge_src #(.N_CH(N_CH)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .rise(rise)
  );

  cli_hl_counter #(.CW(LN_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(en_q), .tick(tick), .vs_rise(vs_rise),
    .count(count_q), .started(started_q), .step(step_q)
  );

  cli_line_window #(.CW(LN_W)) u_win (
    .clk(clk), .rst_n(rst_n), .en(en_q), .step(step_q), .started(started_q),
    .count(count_q), .ln(line_cfg.ln), .rise_sel(line_cfg.rise_sel),
    .win(line_win), .req(req_q)
  );

  cli_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .req(req_q), .ext_irq(ext_irq),
    .line_cfg(line_cfg), .mode_cfg(mode_cfg), .pend(pend_q),
    .line_cfg_rd(line_cfg_rd), .mode_rd(mode_rd), .cpu_irq(cpu_irq)
  );
endmodule

// File: rtl/cli_chk.sv
module cli_chk
  import cli_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            en_q,
  input logic            pend_q,
  input logic            step_q,
  input logic            line_win,
  input logic [LN_W-1:0] count_q
);
  localparam logic [LN_W-1:0] CMAX = {LN_W{1'b1}};

  // R11: a disabled block closes the window on the next edge
  assert_dark_when_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !line_win);

  // R11: the pending flag only rises while enabled
  assert_pend_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(en_q));

  // R3: the count only moves up by one or restarts at zero
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count_q != $past(count_q)) && (count_q != '0) |-> count_q == $past(count_q) + 1'b1);

  // R4: at the top value the count holds or restarts
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(count_q) == CMAX) |-> (count_q == CMAX) || (count_q == '0));

  // R10: the window moves only after a step strobe or while disabled
  assert_win_on_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(line_win) |-> $past(step_q) || !$past(en_q));

  // R5/R6: a new pending flag follows a window edge
  assert_pend_after_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> ($past(line_win) != $past(line_win, 2)));
endmodule

bind caption_line_irq cli_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pend_q(pend_q),
  .step_q(step_q), .line_win(line_win), .count_q(count_q)
);

// File: tb/caption_line_irq_tb_top.sv
module caption_line_irq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       hsync_vid = 1'b0, hdefl_pulse = 1'b0, mid_strobe = 1'b0;
  logic       vsync = 1'b0, ext_irq = 1'b0;
  logic [7:0] line_cfg_rd, mode_rd;
  logic       line_win, cpu_irq;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    int         kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  caption_line_irq dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .hsync_vid(hsync_vid), .hdefl_pulse(hdefl_pulse),
    .mid_strobe(mid_strobe), .vsync(vsync), .ext_irq(ext_irq),
    .line_cfg_rd(line_cfg_rd), .mode_rd(mode_rd),
    .line_win(line_win), .cpu_irq(cpu_irq)
  );

  function automatic logic [7:0] actual(int kind);
    case (kind)
      0:       return {7'b0, line_win};
      1:       return {7'b0, cpu_irq};
      2:       return line_cfg_rd;
      default: return mode_rd;
    endcase
  endfunction

  // monitor: pops every item due in this cycle
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        n_chk++;
        if (actual(sb[i].kind) !== sb[i].exp) begin
          n_fail++;
          $display("FAIL %s kind%0d cyc%0d: actual %h expected %h",
                   sb[i].tag, sb[i].kind, cyc, actual(sb[i].kind), sb[i].exp);
        end
        sb.delete(i);
      end else if (sb[i].due < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s missed check: actual none expected %h", sb[i].tag, sb[i].exp);
        sb.delete(i);
      end
    end
  end

  task automatic expect_at(int dly, int kind, logic [7:0] v, string tag);
    sb.push_back('{cyc + dly, kind, v, tag});
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    @(negedge clk);
  endtask

  // which: 0 video hsync, 1 deflection, 2 midpoint, 3 vsync
  task automatic set_pin(int which, logic v);
    case (which)
      0:       hsync_vid = v;
      1:       hdefl_pulse = v;
      2:       mid_strobe = v;
      default: vsync = v;
    endcase
  endtask

  task automatic pulse(int which, logic ew, logic ei, string tag);
    @(negedge clk);
    set_pin(which, 1'b1);
    expect_at(1, 0, {7'b0, line_win}, "R12 early");
    expect_at(2, 0, {7'b0, ew}, tag);
    expect_at(3, 1, {7'b0, ei}, tag);
    @(negedge clk);
    set_pin(which, 1'b0);
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    expect_at(1, 0, 8'h00, "R1");
    expect_at(1, 1, 8'h00, "R1");
    expect_at(1, 2, 8'h00, "R1");
    expect_at(1, 3, 8'h00, "R1");
    idle(2);

    // R2: enabled, selector 0, no vsync yet
    wr_reg(1'b0, 8'hC0);
    wr_reg(1'b1, 8'h80);
    expect_at(1, 2, 8'hC0, "R1 line readback");
    expect_at(1, 3, 8'h80, "R7 mode readback");
    idle(1);
    pulse(0, 1'b0, 1'b0, "R2");
    pulse(2, 1'b0, 1'b0, "R2");

    // R3/R5/R12: vsync opens window on selector 0
    @(negedge clk);
    vsync = 1'b1;
    expect_at(1, 0, 8'h00, "R12");
    expect_at(2, 0, 8'h01, "R3");
    expect_at(2, 1, 8'h00, "R12");
    expect_at(3, 1, 8'h01, "R5");
    expect_at(3, 3, 8'hC0, "R7 pending bit");
    @(negedge clk);
    vsync = 1'b0;
    idle(3);
    wr_reg(1'b1, 8'h80);
    expect_at(1, 1, 8'h00, "R7 clear");
    expect_at(1, 3, 8'h80, "R7 clear");
    idle(1);
    pulse(2, 1'b0, 1'b0, "R5 fall ignored");

    // R6: falling-edge request on selector 4
    wr_reg(1'b0, 8'h84);
    pulse(3, 1'b0, 1'b0, "R3");
    pulse(0, 1'b0, 1'b0, "R3");
    pulse(2, 1'b0, 1'b0, "R3");
    pulse(0, 1'b0, 1'b0, "R3");
    pulse(2, 1'b1, 1'b0, "R6 rise ignored");
    pulse(0, 1'b0, 1'b1, "R6");
    wr_reg(1'b1, 8'h80);
    expect_at(1, 1, 8'h00, "R7");
    idle(1);

    // R10: writes during an open window
    wr_reg(1'b0, 8'hC4);
    pulse(3, 1'b0, 1'b0, "R10 setup");
    for (int k = 0; k < 3; k++) pulse(k == 1 ? 2 : 0, 1'b0, 1'b0, "R10 setup");
    pulse(2, 1'b1, 1'b1, "R5");
    wr_reg(1'b1, 8'h80);
    wr_reg(1'b0, 8'hC5);
    expect_at(1, 0, 8'h01, "R10");
    expect_at(1, 1, 8'h00, "R10");
    idle(1);
    wr_reg(1'b0, 8'h85);
    wr_reg(1'b0, 8'hC5);
    expect_at(1, 0, 8'h01, "R10");
    expect_at(1, 1, 8'h00, "R10");
    idle(1);
    pulse(0, 1'b1, 1'b0, "R10");
    pulse(2, 1'b0, 1'b0, "R10");

    // R8: external source
    wr_reg(1'b1, 8'hA0);
    expect_at(1, 3, 8'hA0, "R8");
    @(negedge clk);
    ext_irq = 1'b1;
    expect_at(1, 1, 8'h01, "R8");
    idle(2);
    ext_irq = 1'b0;
    expect_at(1, 1, 8'h00, "R8");
    idle(2);
    wr_reg(1'b1, 8'h80);

    // R9: deflection source selected
    wr_reg(1'b0, 8'h04);
    pulse(3, 1'b0, 1'b0, "R9");
    for (int k = 0; k < 4; k++) pulse(0, 1'b0, 1'b0, "R9 video ignored");
    for (int k = 0; k < 3; k++) pulse(1, 1'b0, 1'b0, "R9");
    pulse(1, 1'b1, 1'b0, "R9");
    pulse(1, 1'b0, 1'b1, "R9 fall");
    wr_reg(1'b1, 8'h80);

    // R4: saturation at 63
    wr_reg(1'b0, 8'hFF);
    pulse(3, 1'b0, 1'b0, "R4 setup");
    for (int k = 0; k < 62; k++) pulse(k[0] ? 2 : 0, 1'b0, 1'b0, "R4 setup");
    pulse(0, 1'b1, 1'b1, "R4 reach");
    wr_reg(1'b1, 8'h80);
    for (int k = 0; k < 5; k++) pulse(2, 1'b1, 1'b0, "R4");

    // R11: disable an open window with falling-edge select
    wr_reg(1'b0, 8'hBF);
    wr_reg(1'b1, 8'h00);
    expect_at(1, 0, 8'h00, "R11");
    expect_at(1, 1, 8'h00, "R11");
    expect_at(1, 3, 8'h00, "R11");
    idle(3);
    pulse(3, 1'b0, 1'b0, "R11");
    pulse(0, 1'b0, 1'b0, "R11");
    expect_at(1, 3, 8'h00, "R11 no pending");
    idle(1);

    // R2 again: re-enable, count held until vsync
    wr_reg(1'b0, 8'hC0);
    wr_reg(1'b1, 8'h80);
    pulse(0, 1'b0, 1'b0, "R2");
    pulse(3, 1'b1, 1'b1, "R3");

    idle(5);
    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule